// File: doc/BRIEF.md
# Seconds Timekeeping Counter with Alarm

This block keeps wall time as a free-running binary count clocked by the 32 kHz timebase. The count is 47 bits wide: the upper 32 bits are whole seconds and the lower 15 bits are the fraction of a second, so the seconds field advances once every 32768 clocks. A programmable alarm is compared with the full 47-bit count. On a match it raises a sticky flag, and an enable bit can route that flag to an interrupt output.

Software reaches the block through a plain register port made of a write strobe, a word address, write data and combinational read data. Writes are single-cycle strobes that are already in the counter's clock domain. The counter does not run until its seconds word has been written at least once after reset, even when the run bit is set. Software therefore arms the counter by writing the seconds word (zero is allowed) and then sets the run bit.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and the counter is frozen and not armed.
- R2: Reading offset 0x00 returns the 32 seconds bits of the count. Reading offset 0x04 returns the 15 fraction bits in bits [14:0], with bits above them reading zero.
- R3: While the counter is armed and control bit 3 (offset 0x10) is set, the 47-bit count increases by one on every clock on which the count is not written, and the fraction carries into the seconds.
- R4: A counter whose seconds word has not been written since reset holds its value even with the run bit set. Any write to offset 0x00, including a write of zero, arms it, and it stays armed until reset.
- R5: A write to offset 0x04 loads only the fraction bits and leaves the seconds unchanged. A write to offset 0x00 loads only the seconds and leaves the fraction unchanged. On a cycle with either write, the loaded value replaces the increment.
- R6: The alarm seconds at offset 0x08 (32 bits) and the alarm fraction at offset 0x0C (bits [14:0]) are written and read back.
- R7: Status bit 4 (offset 0x14) is set by the increment that makes the count equal to {alarm seconds, alarm fraction}. Loading the count with a value equal to the alarm does not set it.
- R8: The alarm flag stays set until it is cleared by a write to offset 0x14 with bit 4 set. A write with bit 4 clear has no effect on the flag. A match in the same cycle as a clear leaves the flag set.
- R9: The interrupt output equals the alarm flag ANDed with bit 4 of offset 0x18. The other bits of offset 0x18 read zero.
- R10: Only bit 3 of the control register is stored. Its other bits read zero.
- R11: The count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 5 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| alarm_irq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The assertions check on every cycle that:
- an unarmed counter with no write holds its count;
- an enabled tick adds exactly one;
- arming and the alarm flag never drop on their own;
- each rise of the flag comes from a counting step;
- the interrupt output stays low while it is masked.

Other behaviours depend on sequences of register traffic, so only the bench scenarios can show them. These are the carry from fraction into seconds, field isolation between the two count words, the rule that a load equal to the alarm does not set the flag, set winning over a same-cycle clear, and the 47-bit wrap. The bench compares the read data and the interrupt output with its own model on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register offsets; software depends on these values.
  localparam int unsigned OFS_SEC    = 32'h00;
  localparam int unsigned OFS_FRAC   = 32'h04;
  localparam int unsigned OFS_ASEC   = 32'h08;
  localparam int unsigned OFS_AFRAC  = 32'h0C;
  localparam int unsigned OFS_CTRL   = 32'h10;
  localparam int unsigned OFS_STAT   = 32'h14;
  localparam int unsigned OFS_IEN    = 32'h18;
  // Field positions inside the control, status and enable words.
  localparam int unsigned RUN_BIT    = 3;
  localparam int unsigned ALARM_BIT  = 4;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             sec_wr,
  input  logic             frac_wr,
  input  logic [SEC_W-1:0] wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             tick
);
  logic armed_q;

  function automatic logic [CNT_W-1:0] f_advance(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // A counting step happens only when no load is pending this cycle.
  assign tick = run_en && armed_q && !sec_wr && !frac_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sec_wr) begin
        count_q[CNT_W-1:FRAC_W] <= wdata;
        armed_q <= 1'b1;
      end
      if (frac_wr) count_q[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
      if (tick) count_q <= f_advance(count_q);
    end
  end

  p_frozen_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !sec_wr && !frac_wr) |=> count_q == $past(count_q));
  p_arm_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count_q == $past(count_q) + CNT_W'(1));
  p_load_keeps_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && !frac_wr) |=> count_q[FRAC_W-1:0] == $past(count_q[FRAC_W-1:0]));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  localparam int CNT_W = SEC_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asec_wr,
  input  logic             afrac_wr,
  input  logic [SEC_W-1:0] wdata,
  input  logic             tick,
  input  logic [CNT_W-1:0] count_q,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] alarm_q,
  output logic             flag_q
);
  logic hit;

  function automatic logic f_matches(input logic [CNT_W-1:0] cur,
                                     input logic [CNT_W-1:0] target);
    return (cur + CNT_W'(1)) == target;
  endfunction

  // Only a counting step can match; loads of the count never do.
  assign hit = tick && f_matches(count_q, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (asec_wr)  alarm_q[CNT_W-1:FRAC_W] <= wdata;
      if (afrac_wr) alarm_q[FRAC_W-1:0]     <= wdata[FRAC_W-1:0];
      flag_q <= hit || (flag_q && !flag_clr);
    end
  end

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq
);
  import rtc_pkg::*;
  localparam int CNT_W = SEC_W + FRAC_W;

  logic             run_q, ien_q, tick, flag_q;
  logic [CNT_W-1:0] count_q, alarm_q;
  logic             wr_sec, wr_frac, wr_asec, wr_afrac, wr_ctrl, wr_stat, wr_ien;

  function automatic logic f_sel(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_sec   = wr_en && f_sel(addr, OFS_SEC);
  assign wr_frac  = wr_en && f_sel(addr, OFS_FRAC);
  assign wr_asec  = wr_en && f_sel(addr, OFS_ASEC);
  assign wr_afrac = wr_en && f_sel(addr, OFS_AFRAC);
  assign wr_ctrl  = wr_en && f_sel(addr, OFS_CTRL);
  assign wr_stat  = wr_en && f_sel(addr, OFS_STAT);
  assign wr_ien   = wr_en && f_sel(addr, OFS_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= wr_data[RUN_BIT];
      if (wr_ien)  ien_q <= wr_data[ALARM_BIT];
    end
  end

  rtc_tick_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_en(run_q), .sec_wr(wr_sec), .frac_wr(wr_frac),
    .wdata(wr_data[SEC_W-1:0]), .count_q(count_q), .tick(tick));

  rtc_alarm_match #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .asec_wr(wr_asec), .afrac_wr(wr_afrac),
    .wdata(wr_data[SEC_W-1:0]), .tick(tick), .count_q(count_q),
    .flag_clr(wr_stat && wr_data[ALARM_BIT]), .alarm_q(alarm_q), .flag_q(flag_q));

  always_comb begin
    rd_data = '0;
    if (f_sel(addr, OFS_SEC))   rd_data = DATA_W'(count_q[CNT_W-1:FRAC_W]);
    if (f_sel(addr, OFS_FRAC))  rd_data = DATA_W'(count_q[FRAC_W-1:0]);
    if (f_sel(addr, OFS_ASEC))  rd_data = DATA_W'(alarm_q[CNT_W-1:FRAC_W]);
    if (f_sel(addr, OFS_AFRAC)) rd_data = DATA_W'(alarm_q[FRAC_W-1:0]);
    if (f_sel(addr, OFS_CTRL))  rd_data[RUN_BIT]   = run_q;
    if (f_sel(addr, OFS_STAT))  rd_data[ALARM_BIT] = flag_q;
    if (f_sel(addr, OFS_IEN))   rd_data[ALARM_BIT] = ien_q;
  end

  assign alarm_irq = flag_q && ien_q;

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !alarm_irq);
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> !alarm_irq);
endmodule

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        alarm_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural model state.
  longint unsigned m_sec, m_frac;
  bit m_armed, m_run, m_ien, m_flag;
  longint unsigned m_asec, m_afrac;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_alarm dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq));

  function automatic longint unsigned total(longint unsigned s, longint unsigned f);
    return s * 32768 + f;
  endfunction

  task automatic model_reset();
    m_sec = 0; m_frac = 0; m_armed = 0; m_run = 0; m_ien = 0; m_flag = 0;
    m_asec = 0; m_afrac = 0;
  endtask

  task automatic model_clock(bit we, int a, longint unsigned d);
    bit load, adv, hit, clr;
    longint unsigned nxt;
    load = we && (a == 0 || a == 4);
    adv  = m_run && m_armed && !load;
    nxt  = (total(m_sec, m_frac) + 1) % (longint'(1) << 47);
    hit  = adv && (nxt == total(m_asec, m_afrac));
    clr  = we && a == 'h14 && d[4];
    if (we) begin
      case (a)
        'h00: begin m_sec = d; m_armed = 1; end
        'h04: m_frac = d % 32768;
        'h08: m_asec = d;
        'h0C: m_afrac = d % 32768;
        'h10: m_run = d[3];
        'h18: m_ien = d[4];
        default: ;
      endcase
    end
    if (adv) begin m_sec = nxt / 32768; m_frac = nxt % 32768; end
    m_flag = hit || (m_flag && !clr);
  endtask

  function automatic longint unsigned expect_read(int a);
    case (a)
      'h00: return m_sec;
      'h04: return m_frac;
      'h08: return m_asec;
      'h0C: return m_afrac;
      'h10: return m_run ? 8 : 0;
      'h14: return m_flag ? 16 : 0;
      'h18: return m_ien ? 16 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      'h00, 'h04: return "R2";
      'h08, 'h0C: return "R6";
      'h10: return "R10";
      'h14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(string tag);
    longint unsigned exp_d;
    bit exp_i;
    exp_d = expect_read(int'(addr));
    exp_i = m_flag && m_ien;
    checks++;
    if (rd_data != 32'(exp_d)) begin
      failures++;
      $display("FAIL %s rd_data addr=%h actual=%h expected=%h", tag, addr, rd_data, 32'(exp_d));
    end
    checks++;
    if (alarm_irq != exp_i) begin
      failures++;
      $display("FAIL %s alarm_irq actual=%0b expected=%0b", tag, alarm_irq, exp_i);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare after the edge.
  task automatic step(bit we, int a, longint unsigned d, string tag);
    wr_en = we; addr = 5'(a); wr_data = 32'(d);
    @(posedge clk);
    model_clock(we, a, d);
    @(negedge clk);
    compare(tag == "" ? tag_of(a) : tag);
    wr_en = 1'b0;
  endtask

  task automatic wr(int a, longint unsigned d, string tag);
    step(1'b1, a, d, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, (i % 7) * 4, 0, tag);
  endtask

  task automatic probe(int a, string tag);
    step(1'b0, a, 0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values on every register.
    for (int a = 0; a <= 'h18; a += 4) begin addr = 5'(a); #1; compare("R1"); end
    rst_n = 1'b1;
    idle(7, "R1");

    // R4: enabled but never written seconds stays frozen.
    wr('h10, 32'hFFFF_FFFF, "R10");
    idle(4, "R4");
    probe('h04, "R4");
    // R4: writing zero seconds arms counting.
    wr('h00, 0, "R4");
    idle(10, "R3");
    probe('h04, "R3");

    // R3: fraction carries into seconds.
    wr('h04, 32'hFFFF_7FFC, "R5");
    idle(6, "R3");
    probe('h00, "R3");
    // R5: seconds load keeps fraction; fraction load keeps seconds.
    wr('h00, 32'h0000_1234, "R5");
    probe('h04, "R5");
    wr('h04, 32'h0000_0100, "R5");
    probe('h00, "R5");

    // R6/R7: alarm hit on a counting step, with interrupt enabled.
    wr('h10, 0, "R10");
    wr('h00, 5, "R5");
    wr('h04, 'h10, "R5");
    wr('h08, 5, "R6");
    wr('h0C, 32'hABCD_0014, "R6");
    probe('h0C, "R6");
    wr('h18, 32'hFFFF_FFFF, "R9");
    probe('h18, "R9");
    wr('h10, 8, "R3");
    for (int i = 0; i < 8; i++) probe('h14, "R7");
    // R8: sticky, write of 0 ignored, write of 1 clears.
    wr('h14, 32'hFFFF_FFEF, "R8");
    probe('h14, "R8");
    wr('h14, 'h10, "R8");
    probe('h14, "R8");

    // R7: loading a count equal to the alarm does not set the flag.
    wr('h10, 0, "R7");
    wr('h04, 'h14, "R7");
    probe('h14, "R7");
    probe('h14, "R7");

    // R8: match and clear in the same cycle, set wins.
    wr('h04, 'h13, "R8");
    wr('h10, 8, "R8");
    wr('h14, 'h10, "R8");
    probe('h14, "R8");
    // R9: masked interrupt with flag set.
    wr('h18, 0, "R9");
    probe('h14, "R9");
    wr('h18, 'h10, "R9");
    probe('h14, "R9");
    wr('h14, 'h10, "R8");

    // R11: wrap of the full count.
    wr('h10, 0, "R11");
    wr('h00, 32'hFFFF_FFFF, "R11");
    wr('h04, 32'h0000_7FFF, "R11");
    wr('h10, 8, "R11");
    probe('h00, "R11");
    probe('h04, "R11");
    idle(10, "R3");

    // R1: reset again mid-run returns everything to zero.
    rst_n = 1'b0;
    model_reset();
    #1;
    for (int a = 0; a <= 'h18; a += 4) begin addr = 5'(a); #1; compare("R1"); end
    @(negedge clk);
    rst_n = 1'b1;
    idle(5, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule